// File: doc/BRIEF.md
# Sticky wake-event status register

This block latches wake and interrupt events from sixteen sources into two 8-bit status registers on a simple register bus. It decodes an address, write data, a write strobe and a read strobe, and it returns registered read data. One register holds the eight general-purpose input wake sources. The other holds the parallel-port, serial, floppy, mouse, keyboard, watchdog and SMBus sources. Each source is detected on its rising transition and latches its bit whether or not that source is enabled. Software clears a bit by writing a one to it.

State is cleared only by the standby-power reset. The host-side resets (main power, soft and bus, merged into one input) leave both status registers alone and clear only the read-data register. The parallel-port source reads as a constant 1 while that port is inactive. While the port is active, the source follows the acknowledge line. A combined wake output is formed from the status bits, per-bit enables and a global enable. The enables come from elsewhere as plain inputs.

Top module: `wake_sts_top`

## Requirements
- R1: On standby reset (`stby_rst`=1 at a clock edge) the register at offset 0x08 becomes 0x00 and the register at offset 0x09 becomes 0x01.
- R2: A rising transition of a source sets its status bit at the next clock edge, regardless of any enable. Offset 0x08 bit k maps to `gp_src[k]`. Offset 0x09 bit 0 is the parallel-port source, and bit k+1 maps to `dev_src[k]` (bits 1..7: second serial, first serial, floppy, mouse, keyboard, watchdog, SMBus).
- R3: A write (`wr_en`=1) to 0x08 or 0x09 clears every bit whose `wdata` bit is 1. Bits written with 0 are unchanged.
- R4: If a source's rising transition and a write-1 clear of the same bit fall in the same cycle, the bit stays 1.
- R5: `host_rst`=1 at a clock edge leaves both status registers unchanged and sets `rdata` to 0x00.
- R6: While `pp_active`=0 the parallel-port source is 1. While `pp_active`=1 it equals `pp_nack`. Its rising transitions set offset 0x09 bit 0.
- R7: `wake_out` = `wake_global_en` AND (any bit of `{sts_dev,sts_gp}` AND `{wake_en_dev,wake_en_gp}` is 1). It is combinational from the status registers and the enables.
- R8: A read of any offset other than 0x08 or 0x09 returns 0x00. A write to such an offset changes no status bit.
- R9: `rdata` takes the addressed register value at the clock edge where `rd_en`=1, and it holds that value otherwise. It is visible one cycle after the strobe.
- R10: A source held at 1 does not set its bit again after that bit has been cleared. Only a new rising transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst | input | 1 | Standby-power reset, synchronous, active high |
| host_rst | input | 1 | Merged main-power/soft/bus reset, synchronous, active high |
| gp_src | input | 8 | General-purpose input wake sources |
| dev_src | input | 7 | Device event sources for offset 0x09 bits 1..7 |
| pp_active | input | 1 | Parallel-port activate control |
| pp_nack | input | 1 | Parallel-port acknowledge line |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data (1 = clear bit) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| wake_en_gp | input | 8 | Per-bit wake enables for offset 0x08 |
| wake_en_dev | input | 8 | Per-bit wake enables for offset 0x09 |
| wake_global_en | input | 1 | Global wake enable |
| wake_out | output | 1 | Combined wake request |

## Verification
The bench forces an event and a write-1 clear onto the same edge. A design that gives the clear priority would read the bit back as 0 and lose the event. It holds a source high across a clear to catch a level-sensitive detector, which would set the bit again at once. It asserts the host reset with bits set to expose a design that wrongly clears status on that reset. It also walks the parallel-port source through activation and deactivation; a wrong mux would miss the rising edge that deactivation creates. Random traffic is also compared against a behavioural model on every cycle.

// File: rtl/wake_sts_pkg.sv
package wake_sts_pkg;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned NUM_BANKS = 2;

    localparam logic [ADDR_W-1:0] OFF_GP  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DEV = 8'h09;

    localparam logic [DATA_W-1:0] RST_GP  = 8'h00;
    localparam logic [DATA_W-1:0] RST_DEV = 8'h01;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic hit_dev;
        logic hit_gp;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.hit_gp  = (a == OFF_GP);
        d.hit_dev = (a == OFF_DEV);
        return d;
    endfunction

    function automatic logic pp_source(input logic active, input logic nack);
        return active ? nack : 1'b1;
    endfunction
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= src;
    end

    assign rise = rst ? '0 : (src & ~prev_q);
endmodule

// File: rtl/wake_sts_bank.sv
module wake_sts_bank #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    logic [W-1:0] sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= RST_VAL;
        end else begin
            sts_q <= (sts_q & ~clr) | set;
        end
    end

    assign sts = sts_q;

    for (genvar i = 0; i < W; i++) begin : g_bit_chk
        // R3
        fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(sts_q[i]) |-> $past(clr[i]));
        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> sts_q[i]);
    end
endmodule

// File: rtl/wake_sts_top.sv
module wake_sts_top
    import wake_sts_pkg::*;
(
    input  logic              clk,
    input  logic              stby_rst,
    input  logic              host_rst,
    input  logic [7:0]        gp_src,
    input  logic [6:0]        dev_src,
    input  logic              pp_active,
    input  logic              pp_nack,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] wake_en_gp,
    input  logic [DATA_W-1:0] wake_en_dev,
    input  logic              wake_global_en,
    output logic              wake_out
);
    word_t   src_w  [NUM_BANKS];
    word_t   rise_w [NUM_BANKS];
    word_t   clr_w  [NUM_BANKS];
    word_t   sts_w  [NUM_BANKS];
    word_t   en_w   [NUM_BANKS];
    logic    hit_w  [NUM_BANKS];
    decode_t dec;
    word_t   rd_mux;
    word_t   rdata_q;

    assign dec = decode_addr(addr);

    assign src_w[0] = gp_src;
    assign src_w[1] = {dev_src, pp_source(pp_active, pp_nack)};
    assign hit_w[0] = dec.hit_gp;
    assign hit_w[1] = dec.hit_dev;
    assign en_w[0]  = wake_en_gp;
    assign en_w[1]  = wake_en_dev;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam word_t RV = (b == 0) ? RST_GP : RST_DEV;

        assign clr_w[b] = (wr_en && hit_w[b]) ? wdata : '0;

        wake_edge_det #(.W(DATA_W)) edge_i (
            .clk  (clk),
            .rst  (stby_rst),
            .src  (src_w[b]),
            .rise (rise_w[b])
        );

        wake_sts_bank #(.W(DATA_W), .RST_VAL(RV)) bank_i (
            .clk (clk),
            .rst (stby_rst),
            .set (rise_w[b]),
            .clr (clr_w[b]),
            .sts (sts_w[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_w[b]) rd_mux = rd_mux | sts_w[b];
        end
    end

    always_ff @(posedge clk) begin
        if (stby_rst || host_rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

    always_comb begin
        wake_out = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            wake_out = wake_out | (|(sts_w[b] & en_w[b]));
        end
        wake_out = wake_out & wake_global_en;
    end

    // R5
    host_rst_rdata_chk: assert property (@(posedge clk) disable iff (stby_rst)
        host_rst |=> (rdata == '0));
    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (stby_rst)
        (rd_en && !host_rst && !dec.hit_gp && !dec.hit_dev) |=> (rdata == '0));
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (stby_rst)
        (!rd_en && !host_rst) |=> $stable(rdata));
    // R7
    wake_gated_chk: assert property (@(posedge clk) disable iff (stby_rst)
        wake_out |-> wake_global_en);
endmodule

// File: tb/wake_sts_top_tb_top.sv
module wake_sts_top_tb_top;
    logic       clk = 1'b0;
    logic       stby_rst = 1'b1;
    logic       host_rst = 1'b0;
    logic [7:0] gp_src = '0;
    logic [6:0] dev_src = '0;
    logic       pp_active = 1'b0;
    logic       pp_nack = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] wake_en_gp = '0;
    logic [7:0] wake_en_dev = '0;
    logic       wake_global_en = 1'b0;
    logic       wake_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wake_sts_top dut_i (
        .clk(clk), .stby_rst(stby_rst), .host_rst(host_rst),
        .gp_src(gp_src), .dev_src(dev_src), .pp_active(pp_active), .pp_nack(pp_nack),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .wake_en_gp(wake_en_gp), .wake_en_dev(wake_en_dev),
        .wake_global_en(wake_global_en), .wake_out(wake_out)
    );

    // behavioural reference model
    bit m_sts [16];
    bit m_prev [16];
    int m_rdata = 0;
    bit m_valid = 0;

    function automatic bit src_bit(int i);
        if (i < 8) return gp_src[i];
        if (i == 8) return pp_active ? pp_nack : 1'b1;
        return dev_src[i-9];
    endfunction

    function automatic int reg_val(int base);
        int v = 0;
        for (int k = 0; k < 8; k++) if (m_sts[base+k]) v += (1 << k);
        return v;
    endfunction

    always @(posedge clk) begin
        if (stby_rst) begin
            for (int i = 0; i < 16; i++) begin
                m_prev[i] = src_bit(i);
                m_sts[i] = (i == 8);
            end
            m_rdata = 0;
            m_valid = 1;
        end else begin
            int nr;
            nr = m_rdata;
            if (host_rst) nr = 0;
            else if (rd_en) nr = (addr == 8'h08) ? reg_val(0) :
                                 (addr == 8'h09) ? reg_val(8) : 0;
            for (int i = 0; i < 16; i++) begin
                bit ev, cl;
                ev = src_bit(i) && !m_prev[i];
                cl = wr_en && (addr == ((i < 8) ? 8'h08 : 8'h09)) && wdata[i % 8];
                if (ev) m_sts[i] = 1;
                else if (cl) m_sts[i] = 0;
                m_prev[i] = src_bit(i);
            end
            m_rdata = nr;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            int w = 0;
            for (int i = 0; i < 16; i++) begin
                bit en;
                en = (i < 8) ? wake_en_gp[i] : wake_en_dev[i-8];
                if (m_sts[i] && en) w = 1;
            end
            if (!wake_global_en) w = 0;
            chk("MODEL rdata R9", int'(rdata), m_rdata);
            chk("MODEL wake R7", int'(wake_out), w);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic do_read(logic [7:0] a, int exp, string tag);
        @(negedge clk); #1;
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        chk(tag, int'(rdata), exp);
        #1 rd_en = 1'b0;
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    initial begin : watchdog
        while (cycles < 100000 && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        cyc(3);
        stby_rst = 1'b0;
        // R1 reset values
        do_read(8'h08, 8'h00, "R1 gp reset");
        do_read(8'h09, 8'h01, "R1 dev reset");
        // R2 event latches without enables
        gp_src[3] = 1'b1; cyc(1); gp_src[3] = 1'b0;
        do_read(8'h08, 8'h08, "R2 gp3 latched");
        chk("R7 wake off with enables low", int'(wake_out), 0);
        // R3 write 0 no effect, write 1 clears
        do_write(8'h08, 8'h00);
        do_read(8'h08, 8'h08, "R3 write zero keeps");
        do_write(8'h08, 8'h08);
        do_read(8'h08, 8'h00, "R3 write one clears");
        // R2 device source keyboard -> 0x09 bit5
        dev_src[4] = 1'b1; cyc(1); dev_src[4] = 1'b0;
        do_read(8'h09, 8'h21, "R2 keyboard latched");
        do_write(8'h09, 8'h01);
        do_read(8'h09, 8'h20, "R3 clear pp bit only");
        // R5 host reset keeps status
        host_rst = 1'b1; cyc(2);
        chk("R5 host reset clears rdata", int'(rdata), 0);
        host_rst = 1'b0;
        do_read(8'h09, 8'h20, "R5 status survives host reset");
        // R4 event and clear in same cycle
        @(negedge clk); #1;
        gp_src[0] = 1'b1; addr = 8'h08; wdata = 8'h01; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0; wdata = '0;
        do_read(8'h08, 8'h01, "R4 event beats clear");
        // R10 held level does not re-set
        do_write(8'h08, 8'h01);
        do_read(8'h08, 8'h00, "R10 held level no reset");
        gp_src[0] = 1'b0;
        // R6 parallel-port source
        pp_nack = 1'b0; pp_active = 1'b1; cyc(1);
        do_read(8'h09, 8'h20, "R6 falling source no event");
        pp_nack = 1'b1; cyc(1);
        do_read(8'h09, 8'h21, "R6 nack rise sets bit0");
        do_write(8'h09, 8'h01);
        pp_nack = 1'b0; cyc(1);
        do_read(8'h09, 8'h20, "R6 cleared");
        pp_active = 1'b0; cyc(1);
        do_read(8'h09, 8'h21, "R6 deactivate forces one");
        // R8 unmapped
        do_read(8'h0A, 8'h00, "R8 unmapped read");
        do_write(8'h0A, 8'hFF);
        do_write(8'h07, 8'hFF);
        do_read(8'h09, 8'h21, "R8 unmapped write dev");
        // R9 rdata not visible before the edge
        @(negedge clk); #1;
        addr = 8'h08; rd_en = 1'b1;
        #0.5 chk("R9 rdata before edge", int'(rdata), 8'h21);
        @(negedge clk);
        chk("R9 rdata after edge", int'(rdata), 8'h00);
        #1 rd_en = 1'b0;
        cyc(3);
        chk("R9 rdata holds", int'(rdata), 8'h00);
        // R7 wake combination
        wake_en_dev = 8'h20; #1;
        chk("R7 global off", int'(wake_out), 0);
        wake_global_en = 1'b1; #1;
        chk("R7 enabled bit set", int'(wake_out), 1);
        wake_en_dev = 8'h02; #1;
        chk("R7 enable mismatch", int'(wake_out), 0);
        wake_en_gp = 8'hFF; #1;
        chk("R7 gp empty", int'(wake_out), 0);
        gp_src[7] = 1'b1; cyc(1); gp_src[7] = 1'b0;
        chk("R7 gp7 wakes", int'(wake_out), 1);
        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            gp_src = $urandom; dev_src = $urandom;
            pp_active = $urandom; pp_nack = $urandom;
            addr = 8'h07 + ($urandom % 4);
            wdata = $urandom;
            wr_en = $urandom; rd_en = $urandom;
            host_rst = (($urandom % 16) == 0);
            wake_en_gp = $urandom; wake_en_dev = $urandom;
            wake_global_en = $urandom;
        end
        @(negedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; host_rst = 1'b0;
        // R1 standby reset mid-state
        stby_rst = 1'b1; cyc(2); stby_rst = 1'b0;
        gp_src = '0; dev_src = '0; pp_active = 1'b0;
        do_read(8'h08, 8'h00, "R1 gp after second reset");
        do_read(8'h09, 8'h01, "R1 dev after second reset");
        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule